// File: doc/BRIEF.md
# Multichannel SAR Converter Host Sequencer

This block drives an external 14-bit multichannel successive-approximation converter through its four serial pins: convert strobe, serial clock, configuration data in and result data out. A local request together with a 14-bit configuration word starts one sample. The block raises the convert strobe for a programmed number of system clock cycles and waits out the worst-case conversion time. It then runs one burst of serial clocks. In that burst it shifts the new configuration word out, most significant bit first, and at the same time captures the 14-bit result of the conversion just finished.

The captured result is widened to the output width. In bipolar mode the result is two's complement and is sign-extended. In unipolar mode it is straight binary and is zero-extended. The result is presented with a one-cycle valid pulse and a flag giving the format used. All converter timing limits are parameters counted in system clock cycles: strobe width, conversion time, minimum cycle time, minimum acquisition time and the serial clock half period. The block does not accept a new request until both the cycle-time limit and the acquisition-time limit have been met. It reports this on a ready output.

Top module: `adc_host`

## Requirements
- R1: After reset, cnv_o, sck_o and result_valid are low, result_data is zero, and ready is high.
- R2: A start_req sampled while ready is high raises cnv_o on the next clock edge and keeps it high for exactly CNV_HI_CYC cycles. cfg_word and bipolar are captured on that same edge; later changes to them have no effect on that sample.
- R3: A start_req sampled while ready is low has no effect. It produces no cnv_o rising edge, neither then nor later, because requests are not queued.
- R4: sck_o stays low while cnv_o is high. The first rising edge of sck_o comes no earlier than CONV_CYC cycles after the cnv_o rising edge.
- R5: Each sample produces exactly FRAME_W sck_o pulses. Each pulse is high for SCK_HALF cycles, with SCK_HALF low cycles between pulses, so the burst spans (2*FRAME_W-1)*SCK_HALF cycles from the first rising edge to the last falling edge. sck_o then idles low.
- R6: din_o carries the captured configuration word, most significant bit first. din_o is stable at every sck_o rising edge and changes only on sck_o falling edges, so a receiver sampling on rising edges collects the word in order.
- R7: sdo_i is sampled on each sck_o rising edge. The first sample is the most significant result bit, and bit i of the raw result is the value captured at rising edge FRAME_W-i.
- R8: With the captured bipolar bit at 1, result_data is the raw result sign-extended to OUT_W bits (copies of raw bit FRAME_W-1 fill the upper bits) and result_signed is 1. With the bit at 0, the upper bits are zero and result_signed is 0.
- R9: result_valid is high for exactly one cycle per sample. It rises on the same clock edge as the last falling edge of sck_o.
- R10: Two consecutive cnv_o rising edges are at least CYC_CYC cycles apart. A cnv_o rising edge comes at least ACQ_CYC cycles after the last sck_o falling edge of the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Sample request, taken only while ready is high |
| cfg_word | input | FRAME_W | Configuration word to send during the sample's burst |
| bipolar | input | 1 | 1: result is two's complement and is sign-extended; 0: straight binary |
| ready | output | 1 | Idle and all timing limits met; a request would be taken |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter, idles low |
| din_o | output | 1 | Serial configuration data to the converter |
| sdo_i | input | 1 | Serial result data from the converter |
| result_data | output | OUT_W | Widened conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| result_signed | output | 1 | Format of the presented result (1 = sign-extended) |

## Verification
The bench sweeps several hundred result and configuration patterns through a behavioural converter model. It alternates the mode and includes all-zero, all-one and the values on each side of the sign boundary. A wrong extension would show up as a bad upper byte on exactly those sign-boundary codes. A burst that is off by one edge would shift every received bit and corrupt both the result and the configuration the model collects. Requests are also injected while a conversion is running and during the acquisition window. A design that queued or accepted them would produce an extra strobe edge and break the measured cycle and acquisition gaps. The strobe width, the conversion latency, the pulse count and the burst span are measured on every sample, so that a miscounted divider or timer limit is caught.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STROBE = 2'd1,
      ST_CONV   = 2'd2,
      ST_BURST  = 2'd3
   } host_state_e;

endpackage

// File: rtl/adc_host_interval.sv
// Restartable saturating interval counter: 'expired' goes high LIMIT
// clock edges after the edge on which 'restart' was sampled high.
module adc_host_interval #(
   parameter int unsigned LIMIT = 8,
   parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("adc_host_interval: LIMIT must be at least 1");
   end

   logic [CW-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= CW'(LIMIT);
      end else if (restart) begin
         elapsed <= '0;
      end else if (elapsed != CW'(LIMIT)) begin
         elapsed <= elapsed + 1'b1;
      end
   end

   assign expired = (elapsed == CW'(LIMIT));
endmodule

// File: rtl/adc_host_sckgen.sv
// Serial clock generator: after 'start', produces PULSES clock pulses with
// HALF system cycles per phase, starting with a low phase; idles low.
module adc_host_sckgen #(
   parameter int unsigned HALF   = 4,
   parameter int unsigned PULSES = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic sck,
   output logic rise_tick,
   output logic fall_tick,
   output logic last_fall
);
   localparam int unsigned HW = $clog2(HALF + 1);
   localparam int unsigned PW = $clog2(PULSES + 1);

   if (HALF < 1) begin : g_bad_half
      $error("adc_host_sckgen: HALF must be at least 1");
   end
   if (PULSES < 1) begin : g_bad_pulses
      $error("adc_host_sckgen: PULSES must be at least 1");
   end

   logic          active;
   logic [HW-1:0] hcnt;
   logic [PW-1:0] npulse;
   logic          phase_end;

   assign phase_end = active && (hcnt == HW'(HALF - 1));
   assign rise_tick = phase_end && !sck;
   assign fall_tick = phase_end && sck;
   assign last_fall = fall_tick && (npulse == PW'(PULSES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         hcnt   <= '0;
         npulse <= '0;
         sck    <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         hcnt   <= '0;
         npulse <= '0;
         sck    <= 1'b0;
      end else if (active) begin
         if (phase_end) begin
            hcnt <= '0;
            sck  <= !sck;
            if (fall_tick) begin
               npulse <= npulse + 1'b1;
            end
            if (last_fall) begin
               active <= 1'b0;
            end
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_host_shifter.sv
// Paired shift registers: transmit word leaves MSB first (advanced on the
// falling tick), receive word enters MSB first (sampled on the rising tick).
module adc_host_shifter #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         shift_out,
   input  logic         sample_in,
   input  logic         ser_in,
   output logic         ser_out,
   output logic [W-1:0] rx_word
);
   if (W < 2) begin : g_bad_w
      $error("adc_host_shifter: W must be at least 2");
   end

   logic [W-1:0] tx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_word;
      end else if (shift_out) begin
         tx_q <= {tx_q[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_word <= '0;
      end else if (sample_in) begin
         rx_word <= {rx_word[W-2:0], ser_in};
      end
   end

   assign ser_out = tx_q[W-1];
endmodule

// File: rtl/adc_host_extend.sv
// Widens a raw result: sign extension in two's-complement mode, zero
// extension otherwise; equal widths pass straight through.
module adc_host_extend #(
   parameter int unsigned IN_W  = 14,
   parameter int unsigned OUT_W = 16
) (
   input  logic [IN_W-1:0]  raw,
   input  logic             signed_mode,
   output logic [OUT_W-1:0] ext
);
   if (OUT_W < IN_W) begin : g_bad_width
      $error("adc_host_extend: OUT_W must not be below IN_W");
   end else if (OUT_W == IN_W) begin : g_pass
      assign ext = raw;
   end else begin : g_widen
      localparam int unsigned PAD = OUT_W - IN_W;
      logic fill;
      assign fill = signed_mode & raw[IN_W-1];
      assign ext  = {{PAD{fill}}, raw};
   end
endmodule

// File: rtl/adc_host.sv
module adc_host
   import adc_host_pkg::*;
#(
   parameter int unsigned FRAME_W    = 14,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned SCK_HALF   = 4,
   parameter int unsigned CNV_HI_CYC = 2,
   parameter int unsigned CONV_CYC   = 320,
   parameter int unsigned CYC_CYC    = 500,
   parameter int unsigned ACQ_CYC    = 180
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic [FRAME_W-1:0] cfg_word,
   input  logic               bipolar,
   output logic               ready,
   output logic               cnv_o,
   output logic               sck_o,
   output logic               din_o,
   input  logic               sdo_i,
   output logic [OUT_W-1:0]   result_data,
   output logic               result_valid,
   output logic               result_signed
);
   if (CNV_HI_CYC < 2) begin : g_bad_strobe
      $error("adc_host: CNV_HI_CYC must be at least 2");
   end
   if (CONV_CYC <= CNV_HI_CYC) begin : g_bad_conv
      $error("adc_host: CONV_CYC must exceed CNV_HI_CYC");
   end
   if (CYC_CYC <= CONV_CYC) begin : g_bad_cycle
      $error("adc_host: CYC_CYC must exceed CONV_CYC");
   end
   if (ACQ_CYC < 2) begin : g_bad_acq
      $error("adc_host: ACQ_CYC must be at least 2");
   end

   localparam int unsigned N_TMR   = 3;
   localparam int unsigned T_STROBE = 0;
   localparam int unsigned T_CONV  = 1;
   localparam int unsigned T_CYCLE = 2;
   localparam int unsigned TMR_LIM [N_TMR] = '{CNV_HI_CYC - 1, CONV_CYC - 1, CYC_CYC - 1};

   host_state_e        state_q;
   logic               accept;
   logic               burst_start;
   logic [N_TMR-1:0]   tmr_exp;
   logic               acq_exp;
   logic               mode_q;
   logic               rise_tick;
   logic               fall_tick;
   logic               last_fall;
   logic [FRAME_W-1:0] rx_word;
   logic [OUT_W-1:0]   widened;

   // ---------------- timing guards ----------------
   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      adc_host_interval #(.LIMIT(TMR_LIM[t])) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (accept),
         .expired (tmr_exp[t])
      );
   end

   adc_host_interval #(.LIMIT(ACQ_CYC - 1)) u_acq (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (last_fall),
      .expired (acq_exp)
   );

   assign ready       = (state_q == ST_IDLE) && tmr_exp[T_CYCLE] && acq_exp;
   assign accept      = ready && start_req;
   assign burst_start = (state_q == ST_CONV) && tmr_exp[T_CONV];

   // ---------------- serial clock and data ----------------
   adc_host_sckgen #(.HALF(SCK_HALF), .PULSES(FRAME_W)) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (burst_start),
      .sck       (sck_o),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .last_fall (last_fall)
   );

   adc_host_shifter #(.W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (cfg_word),
      .shift_out (fall_tick),
      .sample_in (rise_tick),
      .ser_in    (sdo_i),
      .ser_out   (din_o),
      .rx_word   (rx_word)
   );

   adc_host_extend #(.IN_W(FRAME_W), .OUT_W(OUT_W)) u_ext (
      .raw         (rx_word),
      .signed_mode (mode_q),
      .ext         (widened)
   );

   // ---------------- sequencing ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         cnv_o         <= 1'b0;
         mode_q        <= 1'b0;
         result_data   <= '0;
         result_valid  <= 1'b0;
         result_signed <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_STROBE;
                  cnv_o   <= 1'b1;
                  mode_q  <= bipolar;
               end
            end
            ST_STROBE: begin
               if (tmr_exp[T_STROBE]) begin
                  state_q <= ST_CONV;
                  cnv_o   <= 1'b0;
               end
            end
            ST_CONV: begin
               if (tmr_exp[T_CONV]) begin
                  state_q <= ST_BURST;
               end
            end
            ST_BURST: begin
               if (last_fall) begin
                  state_q       <= ST_IDLE;
                  result_data   <= widened;
                  result_valid  <= 1'b1;
                  result_signed <= mode_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
   parameter int unsigned FRAME_W    = 14,
   parameter int unsigned CNV_HI_CYC = 2,
   parameter int unsigned CONV_CYC   = 320,
   parameter int unsigned CYC_CYC    = 500
) (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic ready,
   input logic cnv_o,
   input logic sck_o,
   input logic result_valid
);
   localparam int unsigned SW = $clog2(CYC_CYC + 1);
   localparam int unsigned HW = $clog2(CNV_HI_CYC + 2);
   localparam int unsigned NW = $clog2(FRAME_W + 2);

   logic          cnv_d;
   logic          sck_d;
   logic [SW-1:0] since;
   logic [HW-1:0] hi_len;
   logic [NW-1:0] nrise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_d  <= 1'b0;
         sck_d  <= 1'b0;
         since  <= SW'(CYC_CYC);
         hi_len <= '0;
         nrise  <= '0;
      end else begin
         cnv_d <= cnv_o;
         sck_d <= sck_o;
         if (cnv_o && !cnv_d) begin
            since <= SW'(1);
         end else if (since != SW'(CYC_CYC)) begin
            since <= since + 1'b1;
         end
         if (cnv_o && !cnv_d) begin
            hi_len <= HW'(1);
         end else if (cnv_o && hi_len != {HW{1'b1}}) begin
            hi_len <= hi_len + 1'b1;
         end
         if (cnv_o && !cnv_d) begin
            nrise <= '0;
         end else if (sck_o && !sck_d && nrise != {NW{1'b1}}) begin
            nrise <= nrise + 1'b1;
         end
      end
   end

   // R10
   cnv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> since >= SW'(CYC_CYC));

   // R2
   cnv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_o) |-> hi_len == HW'(CNV_HI_CYC));

   // R3
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> ($past(ready) && $past(start_req)));

   // R4
   sck_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> since >= SW'(CONV_CYC));

   // R4
   sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_o |-> !sck_o);

   // R5
   pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> nrise == NW'(FRAME_W));

   // R9
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
endmodule

bind adc_host adc_host_chk #(
   .FRAME_W    (FRAME_W),
   .CNV_HI_CYC (CNV_HI_CYC),
   .CONV_CYC   (CONV_CYC),
   .CYC_CYC    (CYC_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_req    (start_req),
   .ready        (ready),
   .cnv_o        (cnv_o),
   .sck_o        (sck_o),
   .result_valid (result_valid)
);

// File: tb/tb_adc_host.sv
module tb_adc_host;
   localparam int DW   = 14;
   localparam int OW   = 16;
   localparam int HALF = 2;
   localparam int CNVH = 3;
   localparam int CONV = 40;
   localparam int CYC  = 110;
   localparam int ACQ  = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_req = 1'b0;
   logic          bipolar = 1'b0;
   logic [DW-1:0] cfg_word = '0;
   logic          ready, cnv_o, sck_o, din_o, sdo_i;
   logic [OW-1:0] result_data;
   logic          result_valid, result_signed;

   always #5 clk = ~clk;

   adc_host #(
      .FRAME_W(DW), .OUT_W(OW), .SCK_HALF(HALF), .CNV_HI_CYC(CNVH),
      .CONV_CYC(CONV), .CYC_CYC(CYC), .ACQ_CYC(ACQ)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_word(cfg_word),
      .bipolar(bipolar), .ready(ready), .cnv_o(cnv_o), .sck_o(sck_o),
      .din_o(din_o), .sdo_i(sdo_i), .result_data(result_data),
      .result_valid(result_valid), .result_signed(result_signed)
   );

   // ---------------- behavioural converter ----------------
   logic [DW-1:0] model_val = '0;
   logic [DW-1:0] mdl_sreg  = '0;
   logic [DW-1:0] mdl_cfg   = '0;

   always @(posedge cnv_o) begin
      mdl_sreg = model_val;
      mdl_cfg  = '0;
   end
   always @(negedge sck_o) mdl_sreg = {mdl_sreg[DW-2:0], 1'b0};
   always @(posedge sck_o) mdl_cfg = {mdl_cfg[DW-2:0], din_o};
   assign sdo_i = cnv_o ? 1'b0 : mdl_sreg[DW-1];

   // ---------------- pin monitor ----------------
   int   tcyc = 0;
   logic cnv_p = 1'b0, sck_p = 1'b0;
   int   last_rise = -1, gap = 0, acq_gap = 0, last_end = -100000;
   int   hi_len = 0, first_sck = -1, last_fall = 0, n_sck = 0;
   int   n_cnv_rises = 0, hi_run = 0, bad_hi = 0;

   always @(negedge clk) begin
      tcyc++;
      if (cnv_o && !cnv_p) begin
         gap       = (last_rise < 0) ? 1000000 : tcyc - last_rise;
         acq_gap   = tcyc - last_end;
         last_rise = tcyc;
         hi_len    = 0;
         n_sck     = 0;
         first_sck = -1;
         n_cnv_rises++;
      end
      if (cnv_o) hi_len++;
      if (sck_o && !sck_p) begin
         n_sck++;
         if (first_sck < 0) first_sck = tcyc;
         hi_run = 0;
      end
      if (sck_o) hi_run++;
      if (!sck_o && sck_p) begin
         last_fall = tcyc;
         last_end  = tcyc;
         if (hi_run != HALF) bad_hi++;
      end
      cnv_p = cnv_o;
      sck_p = sck_o;
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_sample(input logic [DW-1:0] val, input logic [DW-1:0] cfg,
                             input bit bip, input bit poke);
      int            waitc;
      int            rises0;
      logic [OW-1:0] expv;
      waitc = 0;
      while (!ready && waitc < 10000) begin
         @(negedge clk);
         waitc++;
      end
      model_val = val;
      start_req = 1'b1;
      cfg_word  = cfg;
      bipolar   = bip;
      rises0    = n_cnv_rises;
      @(negedge clk);
      start_req = 1'b0;
      cfg_word  = ~cfg;
      bipolar   = !bip;
      if (poke) begin
         repeat (CNVH + 5) @(negedge clk);
         start_req = 1'b1;
         @(negedge clk);
         start_req = 1'b0;
      end
      waitc = 0;
      while (!result_valid && waitc < 10000) begin
         @(negedge clk);
         waitc++;
      end
      #1;
      expv = bip ? {{(OW-DW){val[DW-1]}}, val} : {{(OW-DW){1'b0}}, val};
      chk(result_valid, "R9", "result_valid seen", result_valid, 1);
      chk(result_data == expv, "R7 R8", "result_data", result_data, expv);
      chk(result_signed == bip, "R8", "result_signed", result_signed, bip);
      chk(mdl_cfg == cfg, "R6", "config received by converter", mdl_cfg, cfg);
      chk(n_cnv_rises - rises0 == 1, "R2 R3", "strobe edges per sample",
          n_cnv_rises - rises0, 1);
      chk(hi_len == CNVH, "R2", "strobe width", hi_len, CNVH);
      chk(first_sck - last_rise >= CONV, "R4", "strobe to first clock",
          first_sck - last_rise, CONV);
      chk(n_sck == DW, "R5", "clock pulses", n_sck, DW);
      chk(last_fall - first_sck == (2*DW-1)*HALF && bad_hi == 0, "R5",
          "burst span", last_fall - first_sck, (2*DW-1)*HALF);
      chk(!sck_o, "R5", "clock idle level", sck_o, 0);
      chk(last_fall == tcyc, "R9", "valid aligned to last clock fall",
          last_fall, tcyc);
      chk(gap >= CYC, "R10", "strobe spacing", gap, CYC);
      chk(acq_gap >= ACQ, "R10", "acquisition gap", acq_gap, ACQ);
      @(negedge clk);
      chk(!result_valid, "R9", "valid width", result_valid, 0);
   endtask

   task automatic poke_in_acquisition();
      int r0;
      int waitc;
      r0 = n_cnv_rises;
      chk(!ready, "R3", "ready during acquisition", ready, 0);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      waitc = 0;
      while (!ready && waitc < 10000) begin
         @(negedge clk);
         waitc++;
      end
      repeat (5) @(negedge clk);
      #1;
      chk(n_cnv_rises == r0, "R3", "strobe edges after ignored request",
          n_cnv_rises, r0);
      chk(!cnv_o, "R3", "strobe stays low", cnv_o, 0);
   endtask

   logic [DW-1:0] corners [8];

   initial begin
      corners = '{14'h0000, 14'h0001, 14'h1FFF, 14'h2000,
                  14'h2001, 14'h3FFE, 14'h3FFF, 14'h2AAA};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk(!cnv_o, "R1", "cnv_o after reset", cnv_o, 0);
      chk(!sck_o, "R1", "sck_o after reset", sck_o, 0);
      chk(!result_valid, "R1", "result_valid after reset", result_valid, 0);
      chk(result_data == '0, "R1", "result_data after reset", result_data, 0);
      chk(ready, "R1", "ready after reset", ready, 1);
      @(negedge clk);

      for (int c = 0; c < 8; c++) begin
         run_sample(corners[c], ~corners[c], 1'b0, 1'b0);
         run_sample(corners[c], corners[c] ^ 14'h1555, 1'b1, (c % 2) == 1);
      end
      poke_in_acquisition();

      for (int i = 0; i < 400; i++) begin
         logic [DW-1:0] v;
         logic [DW-1:0] cf;
         v  = DW'((i * 41) ^ (i << 7));
         cf = DW'(i * 499 + 7);
         run_sample(v, cf, ((i % 2) ^ ((i / 8) % 2)) == 1, (i % 7) == 0);
         if (i % 50 == 49) poke_in_acquisition();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule